// File: doc/BRIEF.md
# Interval Timer Byte Bus Front End

This block sits between an 8-bit register bus and a set of interval-timer channel cores. It exposes a small byte-wide address space. Low addresses are the data ports of the individual channels, and the top address is a control port. Control words do one of three things: they configure a channel (how its count is split into bytes, its operating mode and its decimal-count flag), they snapshot a channel's running count, or they snapshot count and/or status across several channels at once. The channel cores supply their live counts and output levels. The front end assembles written bytes into 16-bit reload values and hands them to the cores as one-cycle load strobes.

Reads of a data port are served in a fixed priority. A pending status snapshot goes out first, then a pending count snapshot, and only after both the live count. Snapshots stay frozen until they have been read out completely, and a new snapshot request for a channel that still holds unread data is dropped. Count and operating behaviour, zero-count expansion and decimal arithmetic belong to the channel cores and are not handled here.

Top module: `tmr_bus_frontend`

## Requirements
- R1: A write to address 3 whose bits 7:6 name a channel below 3 and whose bits 5:4 are nonzero sets that channel's access mode (bits 5:4), operating mode (bits 3:1) and decimal flag (bit 0), visible on the configuration outputs from the next cycle; other channels keep their configuration.
- R2: In access mode 1, a data-port write raises that channel's load strobe for exactly one cycle, starting the cycle after the write, with the written byte as the low byte of the load value and zero as the high byte.
- R3: In access mode 2, a data-port write produces a one-cycle load with the written byte as the high byte and zero as the low byte.
- R4: In access mode 3, the first data-port write produces no load; the second produces a one-cycle load of {second byte, first byte}. A load strobe never occurs without a data write to that channel in the previous cycle.
- R5: A control write with bits 5:4 equal to 0 snapshots the selected channel's live count. Reads then return the frozen snapshot: one byte in access modes 1 (low) and 2 (high), low then high in mode 3. The snapshot is released after its last byte, and live reads resume.
- R6: A count or status snapshot request for a channel that still holds an unread snapshot of that kind is ignored, and the earlier value is kept.
- R7: A control write with bits 7:6 equal to 3 is a multi-channel snapshot: bits 1, 2 and 3 select channels 0, 1 and 2; bit 5 low snapshots the count and bit 4 low snapshots the status. The status byte is {output level in bit 7, bit 6 = 0, access mode in bits 5:4, operating mode in bits 3:1, decimal flag in bit 0}. Unselected channels are untouched.
- R8: A pending status snapshot is returned by the next read ahead of any pending count snapshot and is released by that single read.
- R9: Live reads return the low byte in access mode 1 and the high byte in access mode 2, and alternate low, high, low, ... in access mode 3.
- R10: A configuring control write returns that channel's write and read byte sequencing to the low-byte position.
- R11: After reset every channel is in access mode 3, operating mode 0, decimal flag 0, with no pending snapshots, no load strobe and both sequencers at the low byte.
- R12: A read of address 3 returns 0x00 and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Byte address: 0..2 channel data ports, 3 control port |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; read state advances at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid combinationally while bus_rd is high |
| ch_count | input | NUM_CH*16 | Live count of each channel, channel i at [16*i +: 16] |
| ch_out | input | NUM_CH | Output level of each channel |
| ch_access | output | NUM_CH*2 | Configured access mode per channel |
| ch_mode | output | NUM_CH*3 | Configured operating mode per channel |
| ch_bcd | output | NUM_CH | Configured decimal flag per channel |
| ld_stb | output | NUM_CH | One-cycle load strobe per channel |
| ld_val | output | NUM_CH*16 | Assembled load value, channel i at [16*i +: 16] |

## Verification
On every cycle the assertions check that configuration outputs follow configuring control writes, that load strobes only ever follow a data write to the same channel, that the zero half of a single-byte load really is zero for access modes 1 and 2, and that reads of the control address return zero. The read-side ordering cannot be seen at the ports in a single cycle, and only the directed scenarios show it: status before count, the freezing of snapshots against a changing live count, the dropped second snapshot request, the release after the final byte, and the alternation of live word reads. The same holds for sequencing restarts after reconfiguration and for channel selection by the multi-channel command.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // Byte access selection held per channel (also the bits 5:4 code of a control word)
   typedef enum logic [1:0] {
      ACC_SNAP = 2'd0,
      ACC_LO   = 2'd1,
      ACC_HI   = 2'd2,
      ACC_WORD = 2'd3
   } acc_e;

   localparam logic [1:0] CTRL_PORT = 2'd3;
   localparam logic [1:0] SEL_MULTI = 2'd3;

   function automatic logic [7:0] pack_status(input logic out_lvl, input acc_e acc,
                                               input logic [2:0] mode, input logic bcd);
      return {out_lvl, 1'b0, acc, mode, bcd};
   endfunction
endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode #(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8
) (
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [NUM_CH-1:0] data_we,
   output logic [NUM_CH-1:0] cfg_we,
   output logic [NUM_CH-1:0] snap_cnt,
   output logic [NUM_CH-1:0] snap_st
);
   import tmr_pkg::*;

   logic       ctrl_wr;
   logic [1:0] sel;
   logic [1:0] acc_f;

   assign ctrl_wr = bus_wr && (bus_addr == CTRL_PORT);
   assign sel     = bus_wdata[7:6];
   assign acc_f   = bus_wdata[5:4];

   always_comb begin
      data_we  = '0;
      cfg_we   = '0;
      snap_cnt = '0;
      snap_st  = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         data_we[i] = bus_wr && (bus_addr == 2'(i));
         if (ctrl_wr) begin
            if (sel == SEL_MULTI) begin
               snap_cnt[i] = bus_wdata[i+1] && !bus_wdata[5];
               snap_st[i]  = bus_wdata[i+1] && !bus_wdata[4];
            end else if (sel == 2'(i)) begin
               if (acc_f == ACC_SNAP) snap_cnt[i] = 1'b1;
               else                   cfg_we[i]   = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_word,
   input  logic              snap_cnt,
   input  logic              snap_st,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              rd_en,
   input  logic [CNT_W-1:0]  live_cnt,
   input  logic              out_lvl,
   output logic [DATA_W-1:0] rbyte,
   output logic [1:0]        acc,
   output logic [2:0]        mode,
   output logic              bcd,
   output logic              ld_req,
   output logic [CNT_W-1:0]  ld_word
);
   import tmr_pkg::*;

   acc_e              acc_q;
   logic [2:0]        mode_q;
   logic              bcd_q;
   logic              wr_hi_q;
   logic [DATA_W-1:0] lo_hold_q;
   logic              rd_hi_q;
   logic              cs_vld_q;
   logic              cs_hi_q;
   logic              cs_word_q;
   logic [CNT_W-1:0]  cs_val_q;
   logic              ss_vld_q;
   logic [7:0]        ss_val_q;

   assign acc  = acc_q;
   assign mode = mode_q;
   assign bcd  = bcd_q;

   // Read byte selection, priority: status, count snapshot, live
   always_comb begin
      if (ss_vld_q) begin
         rbyte = ss_val_q;
      end else if (cs_vld_q) begin
         rbyte = cs_hi_q ? cs_val_q[CNT_W-1:DATA_W] : cs_val_q[DATA_W-1:0];
      end else begin
         unique case (acc_q)
            ACC_HI:   rbyte = live_cnt[CNT_W-1:DATA_W];
            ACC_WORD: rbyte = rd_hi_q ? live_cnt[CNT_W-1:DATA_W] : live_cnt[DATA_W-1:0];
            default:  rbyte = live_cnt[DATA_W-1:0];
         endcase
      end
   end

   // Load assembly
   always_comb begin
      ld_req  = 1'b0;
      ld_word = '0;
      if (wr_en) begin
         unique case (acc_q)
            ACC_HI: begin
               ld_req  = 1'b1;
               ld_word = {wr_byte, {DATA_W{1'b0}}};
            end
            ACC_WORD: begin
               ld_req  = wr_hi_q;
               ld_word = {wr_byte, lo_hold_q};
            end
            default: begin
               ld_req  = 1'b1;
               ld_word = {{DATA_W{1'b0}}, wr_byte};
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q     <= ACC_WORD;
         mode_q    <= '0;
         bcd_q     <= 1'b0;
         wr_hi_q   <= 1'b0;
         lo_hold_q <= '0;
         rd_hi_q   <= 1'b0;
         cs_vld_q  <= 1'b0;
         cs_hi_q   <= 1'b0;
         cs_word_q <= 1'b0;
         cs_val_q  <= '0;
         ss_vld_q  <= 1'b0;
         ss_val_q  <= '0;
      end else begin
         if (rd_en) begin
            if (ss_vld_q) begin
               ss_vld_q <= 1'b0;
            end else if (cs_vld_q) begin
               if (cs_word_q && !cs_hi_q) cs_hi_q  <= 1'b1;
               else                       cs_vld_q <= 1'b0;
            end else if (acc_q == ACC_WORD) begin
               rd_hi_q <= !rd_hi_q;
            end
         end
         if (wr_en && acc_q == ACC_WORD) begin
            if (!wr_hi_q) lo_hold_q <= wr_byte;
            wr_hi_q <= !wr_hi_q;
         end
         if (snap_cnt && !cs_vld_q) begin
            cs_vld_q  <= 1'b1;
            cs_val_q  <= live_cnt;
            cs_word_q <= (acc_q == ACC_WORD);
            cs_hi_q   <= (acc_q == ACC_HI);
         end
         if (snap_st && !ss_vld_q) begin
            ss_vld_q <= 1'b1;
            ss_val_q <= pack_status(out_lvl, acc_q, mode_q, bcd_q);
         end
         if (cfg_we) begin
            acc_q   <= acc_e'(cfg_word[5:4]);
            mode_q  <= cfg_word[3:1];
            bcd_q   <= cfg_word[0];
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tmr_bus_frontend.sv
module tmr_bus_frontend #(
   parameter int NUM_CH   = 3,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 16,
   parameter bit LOAD_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              bus_addr,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic [NUM_CH*CNT_W-1:0] ch_count,
   input  logic [NUM_CH-1:0]       ch_out,
   output logic [NUM_CH*2-1:0]     ch_access,
   output logic [NUM_CH*3-1:0]     ch_mode,
   output logic [NUM_CH-1:0]       ch_bcd,
   output logic [NUM_CH-1:0]       ld_stb,
   output logic [NUM_CH*CNT_W-1:0] ld_val
);
   localparam int MAX_CH = 3;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must be between 1 and 3");
   end
   if (DATA_W != 8) begin : g_bad_dw
      $error("DATA_W must be 8");
   end
   if (CNT_W != 2*DATA_W) begin : g_bad_cw
      $error("CNT_W must be twice DATA_W");
   end

   logic [NUM_CH-1:0] data_we, cfg_we, snap_cnt, snap_st;
   logic [NUM_CH-1:0] ld_req;
   logic [CNT_W-1:0]  ld_word [NUM_CH];
   logic [DATA_W-1:0] rbyte   [NUM_CH];

   tmr_ctrl_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dec (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .data_we  (data_we),
      .cfg_we   (cfg_we),
      .snap_cnt (snap_cnt),
      .snap_st  (snap_st)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic rd_sel;
      assign rd_sel = bus_rd && (bus_addr == 2'(i));

      tmr_chan_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg_we  (cfg_we[i]),
         .cfg_word(bus_wdata),
         .snap_cnt(snap_cnt[i]),
         .snap_st (snap_st[i]),
         .wr_en   (data_we[i]),
         .wr_byte (bus_wdata),
         .rd_en   (rd_sel),
         .live_cnt(ch_count[i*CNT_W +: CNT_W]),
         .out_lvl (ch_out[i]),
         .rbyte   (rbyte[i]),
         .acc     (ch_access[i*2 +: 2]),
         .mode    (ch_mode[i*3 +: 3]),
         .bcd     (ch_bcd[i]),
         .ld_req  (ld_req[i]),
         .ld_word (ld_word[i])
      );

      if (LOAD_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ld_stb[i]                <= 1'b0;
               ld_val[i*CNT_W +: CNT_W] <= '0;
            end else begin
               ld_stb[i] <= ld_req[i];
               if (ld_req[i]) ld_val[i*CNT_W +: CNT_W] <= ld_word[i];
            end
         end
      end else begin : g_comb
         assign ld_stb[i]                = ld_req[i];
         assign ld_val[i*CNT_W +: CNT_W] = ld_word[i];
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == 2'(i)) bus_rdata = rbyte[i];
      end
   end
endmodule

// File: rtl/tmr_bus_frontend_chk.sv
module tmr_bus_frontend_chk #(
   parameter int NUM_CH   = 3,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 16,
   parameter bit LOAD_REG = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [1:0]              bus_addr,
   input logic                    bus_wr,
   input logic                    bus_rd,
   input logic [DATA_W-1:0]       bus_wdata,
   input logic [DATA_W-1:0]       bus_rdata,
   input logic [NUM_CH*2-1:0]     ch_access,
   input logic [NUM_CH-1:0]       ld_stb,
   input logic [NUM_CH*CNT_W-1:0] ld_val
);
   // R12
   ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd3) |-> (bus_rdata == '0));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_c
      // R1
      cfg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == 2'(i) && bus_wdata[5:4] != 2'd0)
         |=> (ch_access[i*2 +: 2] == $past(bus_wdata[5:4])));

      if (LOAD_REG) begin : g_r
         // R4
         load_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ld_stb[i] |-> $past(bus_wr && bus_addr == 2'(i)));
      end

      // R2
      lo_only_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_stb[i] && ch_access[i*2 +: 2] == 2'd1) |-> (ld_val[i*CNT_W+DATA_W +: DATA_W] == '0));

      // R3
      hi_only_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_stb[i] && ch_access[i*2 +: 2] == 2'd2) |-> (ld_val[i*CNT_W +: DATA_W] == '0));
   end
endmodule

bind tmr_bus_frontend tmr_bus_frontend_chk #(
   .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W), .LOAD_REG(LOAD_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .ch_access(ch_access),
   .ld_stb   (ld_stb),
   .ld_val   (ld_val)
);

// File: tb/tb_tmr_bus_frontend.sv
module tb_tmr_bus_frontend;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] cnt [NCH];
   logic [NCH*16-1:0] ch_count;
   logic [NCH-1:0]    ch_out = '0;
   logic [NCH*2-1:0]  ch_access;
   logic [NCH*3-1:0]  ch_mode;
   logic [NCH-1:0]    ch_bcd;
   logic [NCH-1:0]    ld_stb;
   logic [NCH*16-1:0] ld_val;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign ch_count = {cnt[2], cnt[1], cnt[0]};

   tmr_bus_frontend dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_count(ch_count), .ch_out(ch_out),
      .ch_access(ch_access), .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ld_stb(ld_stb), .ld_val(ld_val)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      #1;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
      #1;
   endtask

   task automatic read_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
      logic [7:0] d;
      bus_read(a, d);
      chk(req, {8'h00, d}, {8'h00, exp});
   endtask

   task automatic t_reset;
      chk("R11 no strobe", {13'd0, ld_stb}, 16'h0000);
      chk("R11 access", {10'd0, ch_access}, 16'h003F);
      chk("R11 mode", {7'd0, ch_mode}, 16'h0000);
      chk("R11 bcd", {13'd0, ch_bcd}, 16'h0000);
      cnt[1] = 16'hA1B2;
      read_chk("R11 first live read low", 2'd1, 8'hB2);
      read_chk("R9 word live second read high", 2'd1, 8'hA1);
   endtask

   task automatic t_cfg;
      bus_write(2'd3, 8'h55);   // ch1, acc1, mode2, bcd1
      chk("R1 ch1 access", {14'd0, ch_access[3:2]}, 16'd1);
      chk("R1 ch1 mode", {13'd0, ch_mode[5:3]}, 16'd2);
      chk("R1 ch1 bcd", {15'd0, ch_bcd[1]}, 16'd1);
      chk("R1 ch0 untouched", {14'd0, ch_access[1:0]}, 16'd3);
   endtask

   task automatic t_write_lo;
      bus_write(2'd1, 8'h7C);
      chk("R2 strobe", {13'd0, ld_stb}, 16'b010);
      chk("R2 value", ld_val[31:16], 16'h007C);
      @(negedge clk); #1;
      chk("R2 one cycle", {13'd0, ld_stb}, 16'd0);
   endtask

   task automatic t_write_hi;
      bus_write(2'd3, 8'hA0);   // ch2, acc2, mode0
      bus_write(2'd2, 8'h3D);
      chk("R3 strobe", {13'd0, ld_stb}, 16'b100);
      chk("R3 value", ld_val[47:32], 16'h3D00);
   endtask

   task automatic t_write_word;
      bus_write(2'd3, 8'h36);   // ch0, acc3, mode3
      bus_write(2'd0, 8'h34);
      chk("R4 no load on first byte", {13'd0, ld_stb}, 16'd0);
      bus_write(2'd0, 8'h12);
      chk("R4 strobe", {13'd0, ld_stb}, 16'b001);
      chk("R4 value", ld_val[15:0], 16'h1234);
   endtask

   task automatic t_live;
      cnt[1] = 16'hBEEF; cnt[2] = 16'hCAFE; cnt[0] = 16'h5678;
      read_chk("R9 mode1 low", 2'd1, 8'hEF);
      read_chk("R9 mode1 low again", 2'd1, 8'hEF);
      read_chk("R9 mode2 high", 2'd2, 8'hCA);
      read_chk("R9 mode2 high again", 2'd2, 8'hCA);
      read_chk("R9 word lo", 2'd0, 8'h78);
      read_chk("R9 word hi", 2'd0, 8'h56);
      read_chk("R9 word lo again", 2'd0, 8'h78);
      read_chk("R9 word hi again", 2'd0, 8'h56);
   endtask

   task automatic t_snap;
      bus_write(2'd3, 8'h00);   // snapshot ch0 (0x5678)
      cnt[0] = 16'h1111;
      bus_write(2'd3, 8'h00);   // second request must be dropped
      read_chk("R6 first snapshot kept lo", 2'd0, 8'h78);
      read_chk("R5 frozen hi", 2'd0, 8'h56);
      read_chk("R5 released live lo", 2'd0, 8'h11);
      read_chk("R9 live hi", 2'd0, 8'h11);
      cnt[1] = 16'h4455;
      bus_write(2'd3, 8'h40);   // snapshot ch1, mode1
      cnt[1] = 16'h6677;
      read_chk("R5 mode1 frozen", 2'd1, 8'h55);
      read_chk("R5 mode1 released", 2'd1, 8'h77);
   endtask

   task automatic t_multi;
      ch_out = 3'b100;
      cnt[2] = 16'h9ABC; cnt[0] = 16'h2233;
      bus_write(2'd3, 8'hCC);   // count+status, ch1 and ch2
      cnt[2] = 16'h0000; cnt[1] = 16'h0000; cnt[0] = 16'h4455;
      read_chk("R8 ch2 status first", 2'd2, 8'hA0);
      read_chk("R7 ch2 frozen count hi", 2'd2, 8'h9A);
      read_chk("R7 ch2 released", 2'd2, 8'h00);
      read_chk("R7 ch1 status", 2'd1, 8'h15);
      read_chk("R7 ch1 frozen count", 2'd1, 8'h77);
      read_chk("R7 ch0 not selected lo", 2'd0, 8'h55);
      read_chk("R7 ch0 not selected hi", 2'd0, 8'h44);
      bus_write(2'd3, 8'hE2);   // status only, ch0
      read_chk("R7 ch0 status", 2'd0, 8'h36);
      read_chk("R8 status released, live lo", 2'd0, 8'h55);
      read_chk("R9 live hi after status", 2'd0, 8'h44);
   endtask

   task automatic t_seq_restart;
      bus_write(2'd0, 8'hAA);
      bus_write(2'd3, 8'h36);
      bus_write(2'd0, 8'hBB);
      chk("R10 write restarts at low", {13'd0, ld_stb}, 16'd0);
      bus_write(2'd0, 8'hCC);
      chk("R10 load after restart", ld_val[15:0], 16'hCCBB);
      read_chk("R10 read lo", 2'd0, 8'h55);
      bus_write(2'd3, 8'h36);
      read_chk("R10 read restarts at low", 2'd0, 8'h55);
      read_chk("R10 then hi", 2'd0, 8'h44);
   endtask

   task automatic t_ctrl_read;
      read_chk("R12 control read zero", 2'd3, 8'h00);
      read_chk("R12 ch0 sequence untouched", 2'd0, 8'h55);
      chk("R12 no strobe", {13'd0, ld_stb}, 16'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NCH; i++) cnt[i] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_cfg();
      t_write_lo();
      t_write_hi();
      t_write_word();
      t_live();
      t_snap();
      t_multi();
      t_seq_restart();
      t_ctrl_read();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule